// File: doc/BRIEF.md
# Fractional Multiply-Accumulate ALU

This block is the arithmetic engine of a 24-bit fixed-point signal processor. A controller hands it two signed fractional operands, a four-bit operation code and the number of a destination accumulator, and pulses a start strobe. Two clocks later the block pulses done, with the chosen 56-bit accumulator updated and four condition flags refreshed. Operands use the Q1.23 convention, so 0x400000 is one half and 0x800000 is minus one.

Each accumulator has 56 bits. Bits 55..48 are an 8-bit guard extension, bits 47..24 are the high word and bits 23..0 are the low word. A 24-bit operand lines up with the high word. The signed 48-bit product is doubled, which places its binary point at bit 47. Rounding works at the boundary between the high word and the low word and breaks exact ties toward an even high word. Two accumulators are kept, and an operation reads and writes only the one it names.

Top module: `frac_mac_alu`

## Requirements
- R1: After reset both accumulators hold zero, all four flags are 0, and busy and done are 0.
- R2: start is taken only while busy is 0. In the cycle after start is taken, busy is 1. In the cycle after that, done is 1 for exactly one cycle, busy is back to 0, and the result and flags are visible.
- R3: A start that arrives while busy is 1 is ignored. It produces no second done, and it leaves the accumulators unchanged.
- R4: Opcode 0 (multiply) writes the doubled, sign-extended product of A and B to the destination. Minus one times minus one gives 0x00_800000_000000.
- R5: Opcode 1 (multiply-accumulate) adds the doubled product to the destination accumulator.
- R6: Opcode 2 (multiply-accumulate-round) adds the doubled product, then adds 2^23. If the low 24 bits of the sum were exactly 0x800000, bit 24 is cleared. The low 24 bits of the result are then zeroed.
- R7: Opcodes 3 (add) and 4 (subtract) add A to the destination, or subtract A from it. For both, A is sign-extended through bits 55..48 and placed in bits 47..24, with zero in bits 23..0.
- R8: Opcode 5 writes the absolute value of the destination accumulator.
- R9: Opcode 6 (compare) sets the flags from the destination minus the aligned A. Neither accumulator changes.
- R10: Opcode 7 shifts the destination left by one bit. Opcode 8 shifts it right by one bit, arithmetically.
- R11: Opcode 9 (shift-and-add) writes twice the destination plus the aligned A.
- R12: On completion, the flags are set as follows. N is result bit 55. Z is 1 when the result is zero. V marks a signed overflow out of 56 bits, or a change of bit 55 on a left shift. E is 1 when bits 55..47 are not all equal.
- R13: Only the accumulator chosen by the destination select latched at start changes, and it changes only in the done cycle. accOut shows the accumulator chosen by the live dstSel.
- R14: Opcodes 10 to 15 complete with done but change neither the accumulators nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an operation when the block is idle |
| opcode | input | 4 | Operation code |
| dstSel | input | 1 | Destination accumulator; also selects accOut |
| srcA | input | 24 | Signed fractional operand A |
| srcB | input | 24 | Signed fractional operand B |
| busy | output | 1 | First clock of the operation in progress |
| done | output | 1 | Operation completed this cycle |
| accOut | output | 56 | Accumulator selected by dstSel |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagV | output | 1 | Overflow flag |
| flagE | output | 1 | Extension-in-use flag |

## Verification
The hardest cases to reach are the rounding tie and the 56-bit overflow. Both need exact low-word patterns or values deep in the guard bits, and the operands alone cannot supply either. The bench builds them in steps. A multiply of the smallest operand by a chosen fraction loads 0x800000, 0xC00000 or 0x400000 into the low word. An add of one LSB then makes the high word odd. A chain of eight left shifts walks minus one squared up through the extension until the sign bit flips.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_MPY  = 4'd0,
    OP_MAC  = 4'd1,
    OP_MACR = 4'd2,
    OP_ADD  = 4'd3,
    OP_SUB  = 4'd4,
    OP_ABS  = 4'd5,
    OP_CMP  = 4'd6,
    OP_ASL  = 4'd7,
    OP_ASR  = 4'd8,
    OP_ADDL = 4'd9
  } aluOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic            capture;
    logic            writeAcc;
    logic            updFlags;
    logic [OP_W-1:0] op;
  } aluCtrl_t;

endpackage

// File: rtl/frac_mac_ctrl.sv
module frac_mac_ctrl
  import frac_mac_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [OP_W-1:0] opcode,
  output logic            busy,
  output logic            done,
  output aluCtrl_t        ctl
);

  logic            busyQ;
  logic            doneQ;
  logic [OP_W-1:0] opQ;
  logic            opKnown;

  assign opKnown = (opQ <= OP_ADDL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      opQ   <= '0;
    end else begin
      doneQ <= busyQ;
      if (busyQ) begin
        busyQ <= 1'b0;
      end else if (start) begin
        busyQ <= 1'b1;
        opQ   <= opcode;
      end
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.capture  = start && !busyQ;
    ctl.op       = opQ;
    ctl.updFlags = busyQ && opKnown;
    ctl.writeAcc = busyQ && opKnown && (opQ != OP_CMP);
  end

  assign busy = busyQ;
  assign done = doneQ;

endmodule

// File: rtl/frac_mac_dp.sv
module frac_mac_dp
  import frac_mac_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int EXT_W   = 8,
  parameter int NUM_ACC = 2,
  localparam int ACC_W  = EXT_W + 2 * DATA_W,
  localparam int SEL_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  aluCtrl_t                        ctl,
  input  logic [DATA_W-1:0]               srcA,
  input  logic [DATA_W-1:0]               srcB,
  input  logic [SEL_W-1:0]                dstSel,
  output logic [NUM_ACC-1:0][ACC_W-1:0]   accAll,
  output logic                            flagN,
  output logic                            flagZ,
  output logic                            flagV,
  output logic                            flagE
);

  localparam int SUM_W = ACC_W + 1;
  localparam int PRD_W = 2 * DATA_W;
  localparam logic [SUM_W-1:0] ONE_W  = SUM_W'(1);
  localparam logic [SUM_W-1:0] HALF_W = ONE_W << (DATA_W - 1);
  localparam logic [DATA_W-1:0] TIE_LO = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W-1:0] aQ, bQ;
  logic [SEL_W-1:0]         dstQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aQ   <= '0;
      bQ   <= '0;
      dstQ <= '0;
    end else if (ctl.capture) begin
      aQ   <= srcA;
      bQ   <= srcB;
      dstQ <= dstSel;
    end
  end

  logic [ACC_W-1:0]        cur;
  logic signed [PRD_W-1:0] prodRaw;
  logic [ACC_W-1:0]        prodAcc;
  logic [ACC_W-1:0]        opAcc;

  assign cur     = accAll[dstQ];
  assign prodRaw = aQ * bQ;
  assign prodAcc = {{(ACC_W-PRD_W){prodRaw[PRD_W-1]}}, prodRaw} << 1;
  assign opAcc   = {{EXT_W{aQ[DATA_W-1]}}, aQ, {DATA_W{1'b0}}};

  // shared adder operands
  logic [ACC_W-1:0] addL, addR;
  logic             doSub;

  always_comb begin
    addL  = cur;
    addR  = opAcc;
    doSub = 1'b0;
    case (ctl.op)
      OP_MPY:          begin addL = '0; addR = prodAcc; end
      OP_MAC, OP_MACR: begin addR = prodAcc; end
      OP_SUB, OP_CMP:  begin doSub = 1'b1; end
      OP_ABS:          begin addL = '0; addR = cur; doSub = cur[ACC_W-1]; end
      OP_ADDL:         begin addL = cur << 1; end
      default:         ;
    endcase
  end

  logic [SUM_W-1:0] extL, extR, sumW, rndW, roundedW;
  logic             tie;

  assign extL     = {addL[ACC_W-1], addL};
  assign extR     = {addR[ACC_W-1], addR};
  assign sumW     = doSub ? (extL + ~extR + ONE_W) : (extL + extR);
  assign rndW     = sumW + HALF_W;
  assign tie      = (sumW[DATA_W-1:0] == TIE_LO);
  assign roundedW = {rndW[SUM_W-1:DATA_W+1], rndW[DATA_W] & ~tie, {DATA_W{1'b0}}};

  logic [ACC_W-1:0] res;
  logic             vNext;
  logic             shiftV;

  assign shiftV = cur[ACC_W-1] ^ cur[ACC_W-2];

  always_comb begin
    res   = sumW[ACC_W-1:0];
    vNext = sumW[SUM_W-1] ^ sumW[SUM_W-2];
    case (ctl.op)
      OP_MACR: begin
        res   = roundedW[ACC_W-1:0];
        vNext = roundedW[SUM_W-1] ^ roundedW[SUM_W-2];
      end
      OP_ASL: begin
        res   = cur << 1;
        vNext = shiftV;
      end
      OP_ASR: begin
        res   = {cur[ACC_W-1], cur[ACC_W-1:1]};
        vNext = 1'b0;
      end
      OP_ADDL: vNext = shiftV | (sumW[SUM_W-1] ^ sumW[SUM_W-2]);
      default: ;
    endcase
  end

  // one register per accumulator
  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    always_ff @(posedge clk) begin
      if (!rstN)
        accAll[g] <= '0;
      else if (ctl.writeAcc && (dstQ == SEL_W'(g)))
        accAll[g] <= res;
    end
  end

  logic [EXT_W:0] topBits;
  assign topBits = res[ACC_W-1 -: EXT_W+1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagN <= 1'b0;
      flagZ <= 1'b0;
      flagV <= 1'b0;
      flagE <= 1'b0;
    end else if (ctl.updFlags) begin
      flagN <= res[ACC_W-1];
      flagZ <= (res == '0);
      flagV <= vNext;
      flagE <= !((&topBits) || !(|topBits));
    end
  end

endmodule

// File: rtl/frac_mac_alu.sv
module frac_mac_alu
  import frac_mac_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int EXT_W   = 8,
  parameter int NUM_ACC = 2,
  localparam int ACC_W  = EXT_W + 2 * DATA_W,
  localparam int SEL_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [OP_W-1:0]   opcode,
  input  logic [SEL_W-1:0]  dstSel,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic              busy,
  output logic              done,
  output logic [ACC_W-1:0]  accOut,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV,
  output logic              flagE
);

  aluCtrl_t                      ctl;
  logic [NUM_ACC-1:0][ACC_W-1:0] accAll;

  frac_mac_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .opcode (opcode),
    .busy   (busy),
    .done   (done),
    .ctl    (ctl)
  );

  frac_mac_dp #(
    .DATA_W  (DATA_W),
    .EXT_W   (EXT_W),
    .NUM_ACC (NUM_ACC)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .srcA   (srcA),
    .srcB   (srcB),
    .dstSel (dstSel),
    .accAll (accAll),
    .flagN  (flagN),
    .flagZ  (flagZ),
    .flagV  (flagV),
    .flagE  (flagE)
  );

  assign accOut = accAll[dstSel];

endmodule

// File: rtl/frac_mac_chk.sv
module frac_mac_chk
  import frac_mac_pkg::*;
#(
  parameter int ACC_W = 56
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [OP_W-1:0]  opcode,
  input logic             busy,
  input logic             done,
  input logic [ACC_W-1:0] accA,
  input logic [ACC_W-1:0] accB
);

  // R2
  start_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy);

  // R2
  done_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> done && !busy);

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && start |=> !busy);

  // R13
  acc_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(accA) && $stable(accB));

  // R13
  one_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $stable(accA) || $stable(accB));

  // R9
  cmp_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && $past(start && !busy && (opcode == OP_CMP), 2)
      |-> $stable(accA) && $stable(accB));

endmodule

bind frac_mac_alu frac_mac_chk #(.ACC_W(ACC_W)) i_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .opcode (opcode),
  .busy   (busy),
  .done   (done),
  .accA   (accAll[0]),
  .accB   (accAll[1])
);

// File: tb/test_frac_mac_alu.sv
module test_frac_mac_alu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  opcode = '0;
  logic        dstSel = 1'b0;
  logic [23:0] srcA = '0;
  logic [23:0] srcB = '0;
  logic        busy, done;
  logic [55:0] accOut;
  logic        flagN, flagZ, flagV, flagE;

  int checkCount = 0;
  int failCount  = 0;

  frac_mac_alu i_frac_mac_alu (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .dstSel(dstSel),
    .srcA(srcA), .srcB(srcB), .busy(busy), .done(done), .accOut(accOut),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagE(flagE)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] flags();
    return {flagN, flagZ, flagV, flagE};
  endfunction

  // issue one operation; returns at the negedge where done is high
  task automatic runOp(input logic [3:0] op, input logic dst,
                       input logic [23:0] a, input logic [23:0] b);
    @(negedge clk);
    start = 1'b1; opcode = op; dstSel = dst; srcA = a; srcB = b;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic peekAcc(input logic dst, output logic [55:0] v);
    dstSel = dst;
    #1;
    v = accOut;
  endtask

  task automatic testReset();
    logic [55:0] v;
    check("R1 busy", {63'd0, busy}, 64'd0);
    check("R1 done", {63'd0, done}, 64'd0);
    check("R1 flags", {60'd0, flags()}, 64'd0);
    peekAcc(1'b0, v); check("R1 acc0", {8'd0, v}, 64'd0);
    peekAcc(1'b1, v); check("R1 acc1", {8'd0, v}, 64'd0);
  endtask

  task automatic testTiming();
    @(negedge clk);
    start = 1'b1; opcode = 4'd0; dstSel = 1'b0; srcA = 24'h400000; srcB = 24'h400000;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", {62'd0, busy, done}, 64'd2);
    @(negedge clk);
    check("R2 done cycle", {62'd0, busy, done}, 64'd1);
    check("R4 half squared", {8'd0, accOut}, 64'h00_200000_000000);
    @(negedge clk);
    check("R2 done is one cycle", {63'd0, done}, 64'd0);
  endtask

  task automatic testIgnoreBusy();
    @(negedge clk);
    start = 1'b1; opcode = 4'd0; dstSel = 1'b0; srcA = 24'h400000; srcB = 24'h400000;
    @(negedge clk);
    opcode = 4'd3; srcA = 24'h200000;
    @(negedge clk);
    start = 1'b0;
    check("R3 first result", {8'd0, accOut}, 64'h00_200000_000000);
    @(negedge clk);
    check("R3 no second op", {62'd0, busy, done}, 64'd0);
    @(negedge clk);
    check("R3 no late done", {63'd0, done}, 64'd0);
    check("R3 acc untouched", {8'd0, accOut}, 64'h00_200000_000000);
  endtask

  task automatic testMultiply();
    logic [55:0] v;
    runOp(4'd0, 1'b0, 24'h400000, 24'h400000);
    runOp(4'd0, 1'b1, 24'h800000, 24'h800000);
    check("R4 minus one squared", {8'd0, accOut}, 64'h00_800000_000000);
    check("R12 E on extension", {60'd0, flags()}, 64'h1);
    peekAcc(1'b0, v);
    check("R13 other acc kept", {8'd0, v}, 64'h00_200000_000000);
    runOp(4'd1, 1'b0, 24'h400000, 24'h400000);
    check("R5 mac", {8'd0, accOut}, 64'h00_400000_000000);
    runOp(4'd1, 1'b0, 24'hC00000, 24'h400000);
    runOp(4'd1, 1'b0, 24'hC00000, 24'h400000);
    check("R5 mac to zero", {8'd0, accOut}, 64'h0);
    check("R12 Z flag", {60'd0, flags()}, 64'h4);
    peekAcc(1'b1, v);
    check("R13 acc1 after acc0 ops", {8'd0, v}, 64'h00_800000_000000);
  endtask

  task automatic testRound();
    runOp(4'd0, 1'b0, 24'h000001, 24'h400000);
    check("R4 tiny product", {8'd0, accOut}, 64'h00_000000_800000);
    runOp(4'd2, 1'b0, 24'h0, 24'h0);
    check("R6 tie to even down", {8'd0, accOut}, 64'h0);
    runOp(4'd0, 1'b0, 24'h000001, 24'h400000);
    runOp(4'd3, 1'b0, 24'h000001, 24'h0);
    check("R7 add one lsb", {8'd0, accOut}, 64'h00_000001_800000);
    runOp(4'd2, 1'b0, 24'h0, 24'h0);
    check("R6 tie odd up", {8'd0, accOut}, 64'h00_000002_000000);
    runOp(4'd0, 1'b0, 24'h000001, 24'h600000);
    runOp(4'd2, 1'b0, 24'h0, 24'h0);
    check("R6 above half", {8'd0, accOut}, 64'h00_000001_000000);
    runOp(4'd0, 1'b0, 24'h000001, 24'h200000);
    runOp(4'd2, 1'b0, 24'h0, 24'h0);
    check("R6 below half", {8'd0, accOut}, 64'h0);
  endtask

  task automatic testAddSubAbsCmp();
    runOp(4'd0, 1'b0, 24'h400000, 24'h400000);
    runOp(4'd3, 1'b0, 24'h200000, 24'h0);
    check("R7 add", {8'd0, accOut}, 64'h00_400000_000000);
    runOp(4'd4, 1'b0, 24'h600000, 24'h0);
    check("R7 sub negative", {8'd0, accOut}, 64'hFF_E00000_000000);
    check("R12 N flag", {60'd0, flags()}, 64'h8);
    runOp(4'd5, 1'b0, 24'h0, 24'h0);
    check("R8 abs", {8'd0, accOut}, 64'h00_200000_000000);
    runOp(4'd6, 1'b0, 24'h200000, 24'h0);
    check("R9 cmp equal flags", {60'd0, flags()}, 64'h4);
    check("R9 cmp acc kept", {8'd0, accOut}, 64'h00_200000_000000);
    runOp(4'd6, 1'b0, 24'h400000, 24'h0);
    check("R9 cmp less flags", {60'd0, flags()}, 64'h8);
    runOp(4'd9, 1'b0, 24'h200000, 24'h0);
    check("R11 shift and add", {8'd0, accOut}, 64'h00_600000_000000);
  endtask

  task automatic testShift();
    runOp(4'd0, 1'b1, 24'h800000, 24'h800000);
    for (int i = 0; i < 7; i++) runOp(4'd7, 1'b1, 24'h0, 24'h0);
    check("R10 seven left shifts", {8'd0, accOut}, 64'h40_000000_000000);
    check("R12 no overflow yet", {60'd0, flags()}, 64'h1);
    runOp(4'd7, 1'b1, 24'h0, 24'h0);
    check("R10 sign flip", {8'd0, accOut}, 64'h80_000000_000000);
    check("R12 V on shift", {60'd0, flags()}, 64'hB);
    runOp(4'd8, 1'b1, 24'h0, 24'h0);
    check("R10 arith right", {8'd0, accOut}, 64'hC0_000000_000000);
    check("R12 flags after asr", {60'd0, flags()}, 64'h9);
  endtask

  task automatic testUndefined();
    runOp(4'd12, 1'b1, 24'h400000, 24'h400000);
    check("R14 acc kept", {8'd0, accOut}, 64'hC0_000000_000000);
    check("R14 flags kept", {60'd0, flags()}, 64'h9);
    runOp(4'd15, 1'b1, 24'h123456, 24'h7FFFFF);
    check("R14 done seen", {63'd0, done}, 64'd1);
    check("R14 acc kept again", {8'd0, accOut}, 64'hC0_000000_000000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTiming();
    testIgnoreBusy();
    testMultiply();
    testRound();
    testAddSubAbsCmp();
    testShift();
    testUndefined();
    @(negedge clk);
    $display("  %0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule